// File: doc/BRIEF.md
# Core Sleep and Wake Controller

This block lets each of two processor cores be parked and later released, or interrupted, on timed events. Every core owns a 32-bit control word with three parts. A flow field holds three independent flags. A set of event-source selects picks one or more of four tick inputs: system clock, microsecond, millisecond and second. An 8-bit limit N makes the event fire on the (N+1)th selected tick counted after the word was written, so a limit of X−1 wakes on the Xth tick.

The flags can be combined. The stop-on-event flag holds the core until the event. The stop-on-interrupt flag holds it until its interrupt-pending input is seen high. The interrupt flag raises a one-cycle wake interrupt when the operation completes. The operation completes on the event or, if stop-on-interrupt is set, on a pending interrupt, whichever comes first. The flow field then clears, so the core keeps running until software writes the word again. The tick generators and the cores themselves are outside the block.

Top module: `core_flow_ctrl`

## Requirements
- R1: After reset every coreRun bit is 1, every wakeIrq bit is 0 and every control word reads 0.
- R2: Control word layout: bits 31:29 are the flow flags (bit 31 = stop until interrupt, bit 30 = stop until event, bit 29 = interrupt on completion). Bits 27, 25, 24 and 23 select the system clock, microsecond, millisecond and second ticks. Bits 7:0 hold the limit N. All other bits read back 0.
- R3: The event fires on the (N+1)th selected tick after the write, counted at clock edges where the tick input is high. N=0 fires on the first tick.
- R4: With bit 30 set, coreRun is 0 from the cycle after the write until the cycle after the edge that takes the event tick.
- R5: With only bit 31 set, the core stays stalled whatever the ticks do, and resumes in the cycle after irqPending is sampled high.
- R6: With only bit 29 set, coreRun stays 1, and wakeIrq is high for exactly one cycle, in the cycle after the event tick.
- R7: With bit 29 and a stop flag set, wakeIrq pulses for one cycle in the same cycle that coreRun returns to 1, whichever condition caused the release.
- R8: With bits 31 and 30 both set, whichever of the event and the pending interrupt comes first releases the core.
- R9: On completion the flow field reads 000 and the source and limit fields keep their values.
- R10: When several sources are selected, ticks arriving together in one cycle count as one event. Ticks on unselected sources are not counted. With no source selected the event never fires.
- R11: Every write to a core's word restarts its tick count from zero.
- R12: A write or condition for one core does not change the other core's word, coreRun or wakeIrq.
- R13: When a write lands in the same cycle as a completion on that core, the written value is kept, and neither the flow clear nor a wake interrupt takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for a control word |
| wrSel | input | 1 | Core index for the write (SEL_W bits) |
| wrData | input | 32 | Value to write |
| tickSys | input | 1 | System-clock event pulse |
| tickUs | input | 1 | Microsecond tick pulse |
| tickMs | input | 1 | Millisecond tick pulse |
| tickSec | input | 1 | Second tick pulse |
| irqPending | input | 2 | Per-core interrupt-pending level |
| coreRun | output | 2 | Per-core run (1) / stall (0) |
| wakeIrq | output | 2 | Per-core one-cycle wake interrupt |
| rdData | output | 64 | Control words, core 0 in bits 31:0 |

## Verification
The bench probes the count boundary from both sides. A design that counts N ticks instead of N+1 releases one tick early, and one that counts past the limit stays stalled when N=0 should fire at once. It pulses two selected sources in the same cycle: a design that adds them releases a tick too soon. It rewrites a word mid-count: a design that keeps the old count releases early. It also lands a write on the completion edge, where a design that lets the clear win would drop the new word and start the core.

// File: rtl/core_flow_pkg.sv
package core_flow_pkg;

  localparam int REG_W = 32;
  localparam int CNT_W = 8;

  // flow flag positions
  localparam int FLOW_IRQ_BIT  = 29;
  localparam int FLOW_EVT_BIT  = 30;
  localparam int FLOW_WAIT_BIT = 31;

  // event source select positions
  localparam int SRC_SYS_BIT = 27;
  localparam int SRC_US_BIT  = 25;
  localparam int SRC_MS_BIT  = 24;
  localparam int SRC_SEC_BIT = 23;
  localparam int NUM_SRC     = 4;

  localparam logic [REG_W-1:0] FLOW_MASK = 32'hE000_0000;
  localparam logic [REG_W-1:0] SRC_MASK  =
      (32'd1 << SRC_SYS_BIT) | (32'd1 << SRC_US_BIT) |
      (32'd1 << SRC_MS_BIT)  | (32'd1 << SRC_SEC_BIT);
  localparam logic [REG_W-1:0] CNT_MASK  = (32'd1 << CNT_W) - 32'd1;
  localparam logic [REG_W-1:0] WR_MASK   = FLOW_MASK | SRC_MASK | CNT_MASK;

  typedef struct packed {
    logic waitIrq;   // stall until interrupt pending
    logic waitEvt;   // stall until event
    logic irqOnDone; // raise wake interrupt on completion
  } flowFlags_t;

  typedef struct packed {
    logic loadReg;
    logic clearFlow;
    logic countStep;
    logic countRestart;
  } flowStrobe_t;

endpackage

// File: rtl/flow_datapath.sv
module flow_datapath
  import core_flow_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  flowStrobe_t          strobe,
  input  logic [REG_W-1:0]     wrData,
  input  logic [NUM_SRC-1:0]   ticks,      // {sys, us, ms, sec}
  output flowFlags_t           flowQ,
  output logic                 eventTick,
  output logic                 cntAtLimit,
  output logic [REG_W-1:0]     rdData
);

  logic [REG_W-1:0]   ctrlQ;
  logic [CNT_W-1:0]   evCntQ;
  logic [NUM_SRC-1:0] srcSel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrlQ <= '0;
    end else if (strobe.loadReg) begin
      ctrlQ <= wrData & WR_MASK;
    end else if (strobe.clearFlow) begin
      ctrlQ[FLOW_WAIT_BIT:FLOW_IRQ_BIT] <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evCntQ <= '0;
    end else if (strobe.loadReg || strobe.countRestart) begin
      evCntQ <= '0;
    end else if (strobe.countStep) begin
      evCntQ <= evCntQ + 1'b1;
    end
  end

  assign srcSel = {ctrlQ[SRC_SYS_BIT], ctrlQ[SRC_US_BIT],
                   ctrlQ[SRC_MS_BIT],  ctrlQ[SRC_SEC_BIT]};

  assign flowQ      = flowFlags_t'(ctrlQ[FLOW_WAIT_BIT:FLOW_IRQ_BIT]);
  assign eventTick  = |(srcSel & ticks);
  assign cntAtLimit = (evCntQ == ctrlQ[CNT_W-1:0]);
  assign rdData     = ctrlQ;

endmodule

// File: rtl/flow_control.sv
module flow_control
  import core_flow_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrHit,
  input  flowFlags_t  flowQ,
  input  logic        eventTick,
  input  logic        cntAtLimit,
  input  logic        irqPending,
  output flowStrobe_t strobe,
  output logic        coreRun,
  output logic        wakeIrq
);

  logic counting;
  logic eventHit;
  logic irqRelease;
  logic done;
  logic wakeIrqQ;

  assign counting   = flowQ.irqOnDone | flowQ.waitEvt;
  assign eventHit   = counting & eventTick & cntAtLimit;
  assign irqRelease = flowQ.waitIrq & irqPending;
  assign done       = eventHit | irqRelease;

  always_comb begin
    strobe              = '0;
    strobe.loadReg      = wrHit;
    strobe.clearFlow    = done & ~wrHit;
    strobe.countStep    = counting & eventTick & ~cntAtLimit;
    strobe.countRestart = eventHit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wakeIrqQ <= 1'b0;
    else        wakeIrqQ <= flowQ.irqOnDone & done & ~wrHit;
  end

  assign wakeIrq = wakeIrqQ;
  assign coreRun = ~(flowQ.waitEvt | flowQ.waitIrq);

endmodule

// File: rtl/core_flow_ctrl.sv
module core_flow_ctrl
  import core_flow_pkg::*;
#(
  parameter int NUM_CORES = 2,
  localparam int SEL_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
)(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wrEn,
  input  logic [SEL_W-1:0]           wrSel,
  input  logic [REG_W-1:0]           wrData,
  input  logic                       tickSys,
  input  logic                       tickUs,
  input  logic                       tickMs,
  input  logic                       tickSec,
  input  logic [NUM_CORES-1:0]       irqPending,
  output logic [NUM_CORES-1:0]       coreRun,
  output logic [NUM_CORES-1:0]       wakeIrq,
  output logic [NUM_CORES*REG_W-1:0] rdData
);

  logic [NUM_SRC-1:0] ticks;
  assign ticks = {tickSys, tickUs, tickMs, tickSec};

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    flowStrobe_t strobe;
    flowFlags_t  flowQ;
    logic        eventTick;
    logic        cntAtLimit;
    logic        wrHit;

    assign wrHit = wrEn && (wrSel == SEL_W'(c));

    flow_control u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wrHit      (wrHit),
      .flowQ      (flowQ),
      .eventTick  (eventTick),
      .cntAtLimit (cntAtLimit),
      .irqPending (irqPending[c]),
      .strobe     (strobe),
      .coreRun    (coreRun[c]),
      .wakeIrq    (wakeIrq[c])
    );

    flow_datapath u_dp (
      .clk        (clk),
      .rst_n      (rst_n),
      .strobe     (strobe),
      .wrData     (wrData),
      .ticks      (ticks),
      .flowQ      (flowQ),
      .eventTick  (eventTick),
      .cntAtLimit (cntAtLimit),
      .rdData     (rdData[c*REG_W +: REG_W])
    );
  end

endmodule

// File: rtl/core_flow_checker.sv
module core_flow_checker
  import core_flow_pkg::*;
#(
  parameter int NUM_CORES = 2,
  localparam int SEL_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
)(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wrEn,
  input logic [SEL_W-1:0]           wrSel,
  input logic                       tickSys,
  input logic                       tickUs,
  input logic                       tickMs,
  input logic                       tickSec,
  input logic [NUM_CORES-1:0]       irqPending,
  input logic [NUM_CORES-1:0]       coreRun,
  input logic [NUM_CORES-1:0]       wakeIrq,
  input logic [NUM_CORES*REG_W-1:0] rdData
);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    logic [REG_W-1:0] word;
    logic [2:0]       flow;
    logic             selTick;
    logic             wr;

    assign word    = rdData[c*REG_W +: REG_W];
    assign flow    = word[FLOW_WAIT_BIT:FLOW_IRQ_BIT];
    assign selTick = (word[SRC_SYS_BIT] & tickSys) | (word[SRC_US_BIT] & tickUs) |
                     (word[SRC_MS_BIT] & tickMs)   | (word[SRC_SEC_BIT] & tickSec);
    assign wr      = wrEn && (wrSel == SEL_W'(c));

    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!coreRun[c] && !wr && !irqPending[c] && !selTick) |=> !coreRun[c]);

    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wakeIrq[c] |=> !wakeIrq[c]);

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wakeIrq[c] |-> ($past(flow[0]) && !$past(wr)));

    assert_release_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(coreRun[c]) && !$past(wr)) |-> $past(irqPending[c] || selTick));

    assert_flow_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(coreRun[c]) && !$past(wr)) |-> (flow == 3'b000));
  end

endmodule

bind core_flow_ctrl core_flow_checker #(.NUM_CORES(NUM_CORES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wrEn       (wrEn),
  .wrSel      (wrSel),
  .tickSys    (tickSys),
  .tickUs     (tickUs),
  .tickMs     (tickMs),
  .tickSec    (tickSec),
  .irqPending (irqPending),
  .coreRun    (coreRun),
  .wakeIrq    (wakeIrq),
  .rdData     (rdData)
);

// File: tb/core_flow_ctrl_bench.sv
`timescale 1ns/1ps
module core_flow_ctrl_bench;

  localparam logic [31:0] F_IRQ  = 32'h2000_0000;
  localparam logic [31:0] F_EVT  = 32'h4000_0000;
  localparam logic [31:0] F_WAIT = 32'h8000_0000;
  localparam logic [31:0] S_SYS  = 32'h0800_0000;
  localparam logic [31:0] S_US   = 32'h0200_0000;
  localparam logic [31:0] S_MS   = 32'h0100_0000;
  localparam logic [31:0] S_SEC  = 32'h0080_0000;
  localparam logic [3:0]  T_SYS = 4'b1000, T_US = 4'b0100, T_MS = 4'b0010, T_SEC = 4'b0001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [0:0]  wrSel = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  tickVec = '0;
  logic [1:0]  irqPending = '0;
  logic [1:0]  coreRun;
  logic [1:0]  wakeIrq;
  logic [63:0] rdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  core_flow_ctrl u_core_flow_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .tickSys(tickVec[3]), .tickUs(tickVec[2]), .tickMs(tickVec[1]), .tickSec(tickVec[0]),
    .irqPending(irqPending), .coreRun(coreRun), .wakeIrq(wakeIrq), .rdData(rdData)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end right after a falling edge
  task automatic doWrite(int core, logic [31:0] v);
    wrEn = 1'b1; wrSel = core[0:0]; wrData = v;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseTick(logic [3:0] t);
    tickVec = t;
    @(negedge clk);
    tickVec = '0;
  endtask

  task automatic pulseIrq(int core);
    irqPending[core] = 1'b1;
    @(negedge clk);
    irqPending = '0;
  endtask

  task automatic t_reset;
    check("R1 run", coreRun, 2'b11);
    check("R1 irq", wakeIrq, 2'b00);
    check("R1 words", rdData, 64'h0);
  endtask

  task automatic t_layout;
    doWrite(0, 32'hFFFF_FFFF);
    check("R2 readback", rdData[31:0], 32'hEB80_00FF);
    doWrite(0, 32'h0);
    check("R2 cleared", coreRun[0], 1'b1);
  endtask

  task automatic t_stopEvent;
    doWrite(0, F_EVT | S_US | 32'd2);
    check("R4 stalled", coreRun[0], 1'b0);
    pulseTick(T_US);
    pulseTick(T_US);
    check("R3 not before N+1", coreRun[0], 1'b0);
    pulseTick(T_US);
    check("R3 R4 released", coreRun[0], 1'b1);
    check("R9 flow cleared", rdData[31:0], S_US | 32'd2);
    check("R4 no irq", wakeIrq[0], 1'b0);
  endtask

  task automatic t_irqEvent;
    doWrite(0, F_IRQ | S_SEC);
    check("R6 not stalled", coreRun[0], 1'b1);
    pulseTick(T_SEC);
    check("R6 R3 irq on first tick", wakeIrq[0], 1'b1);
    check("R6 run", coreRun[0], 1'b1);
    @(negedge clk);
    check("R6 one cycle", wakeIrq[0], 1'b0);
  endtask

  task automatic t_stopIrq;
    doWrite(0, F_WAIT | S_MS);
    pulseTick(T_MS);
    pulseTick(T_MS);
    check("R5 ticks ignored", coreRun[0], 1'b0);
    pulseIrq(0);
    check("R5 released", coreRun[0], 1'b1);
    check("R5 no irq", wakeIrq[0], 1'b0);
  endtask

  task automatic t_resumeIrq;
    doWrite(0, F_WAIT | F_IRQ);
    check("R7 stalled", coreRun[0], 1'b0);
    pulseIrq(0);
    check("R7 run", coreRun[0], 1'b1);
    check("R7 irq on resume", wakeIrq[0], 1'b1);
    doWrite(0, F_EVT | F_IRQ | S_SYS);
    check("R7 irq dropped", wakeIrq[0], 1'b0);
    pulseTick(T_SYS);
    check("R7 event run", coreRun[0], 1'b1);
    check("R7 event irq", wakeIrq[0], 1'b1);
    @(negedge clk);
  endtask

  task automatic t_combined;
    doWrite(0, F_EVT | F_WAIT | S_SYS | 32'd3);
    pulseTick(T_SYS);
    check("R8 stalled", coreRun[0], 1'b0);
    pulseIrq(0);
    check("R8 irq first", coreRun[0], 1'b1);
    doWrite(0, F_EVT | F_WAIT | S_SYS | 32'd3);
    for (int k = 0; k < 3; k++) pulseTick(T_SYS);
    check("R8 before event", coreRun[0], 1'b0);
    pulseTick(T_SYS);
    check("R8 event first", coreRun[0], 1'b1);
  endtask

  task automatic t_multiSrc;
    doWrite(0, F_EVT | S_US | S_MS | 32'd2);
    pulseTick(T_US | T_MS);
    pulseTick(T_SYS);
    pulseTick(T_SEC);
    pulseTick(T_MS);
    check("R10 coincident counts once", coreRun[0], 1'b0);
    pulseTick(T_US);
    check("R10 third event", coreRun[0], 1'b1);
    doWrite(0, F_EVT);
    pulseTick(4'hF);
    pulseTick(4'hF);
    check("R10 no source never fires", coreRun[0], 1'b0);
    doWrite(0, 32'h0);
  endtask

  task automatic t_restart;
    doWrite(0, F_EVT | S_US | 32'd1);
    pulseTick(T_US);
    doWrite(0, F_EVT | S_US | 32'd1);
    pulseTick(T_US);
    check("R11 count restarted", coreRun[0], 1'b0);
    pulseTick(T_US);
    check("R11 released", coreRun[0], 1'b1);
  endtask

  task automatic t_indep;
    doWrite(1, F_EVT | S_SEC);
    check("R12 core0 untouched", coreRun, 2'b01);
    check("R12 word0", rdData[31:0], S_US | 32'd1);
    pulseIrq(0);
    check("R12 other irq", coreRun[1], 1'b0);
    pulseTick(T_SEC);
    check("R12 core1 released", coreRun, 2'b11);
    check("R12 no irq", wakeIrq, 2'b00);
  endtask

  task automatic t_writeWins;
    doWrite(0, F_EVT | F_IRQ | S_US);
    wrEn = 1'b1; wrSel = 1'b0; wrData = F_EVT | S_MS; tickVec = T_US;
    @(negedge clk);
    wrEn = 1'b0; tickVec = '0;
    check("R13 write kept", rdData[31:0], F_EVT | S_MS);
    check("R13 still stalled", coreRun[0], 1'b0);
    check("R13 no irq", wakeIrq[0], 1'b0);
    pulseTick(T_MS);
    check("R13 new word works", coreRun[0], 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_stopEvent();
    t_irqEvent();
    t_stopIrq();
    t_resumeIrq();
    t_combined();
    t_multiSrc();
    t_restart();
    t_indep();
    t_writeWins();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule